// File: doc/BRIEF.md
# Smart-Card Character Receiver with Parity Error Signalling

This block receives asynchronous characters from a smart card over one shared, open-drain I/O line. Bit timing comes from the card clock, which the block's `clk` carries. One bit lasts `BIT_CYCLES` clock cycles, 372 by default. A character is ten bits long: a low start bit, eight data bits sent least significant bit first, and one even-parity bit. Each bit is sampled once, near the middle of its period. The sample point is counted from the falling edge of the start bit, as detected after a two-flop synchronizer. With no clock drift and a 50% duty cycle, this mid-bit sample leaves a reception margin of about 49.87% of a bit: half a bit less half a clock cycle.

When the parity is wrong, the receiver pulls the line low for an error-signal window. That pulse asks the sender to repeat the character. The receiver also sets a sticky parity-error flag and does not mark any data as available, so the repeated copy takes the place of the bad one. When the parity is correct, the receiver leaves the line released during the error window. It stores the byte and raises `rx_valid`.

Received bytes leave on a valid/ready port. `rx_valid` stays high until a cycle with `rx_ready` high, which acts as the read strobe from a CPU or DMA engine. The serial line cannot be stalled, so the port has no back-pressure toward the card: a good character that arrives while `rx_valid` is still high replaces the byte being held. The interrupt requests are levels, gated by one receive-interrupt enable.

Top module: `scrx_rx`

## Requirements
- R1: After reset, `rx_valid`, `per_flag`, `rxi_irq`, `eri_irq` and `line_pull_low` are all 0.
- R2: Each bit is sampled at cycle `SAMPLE_AT` (186) of its `BIT_CYCLES`-cycle period, counted from the synchronized falling edge of the start bit. If the start bit reads high at its sample point, the frame is dropped: no flag changes and the line is not driven.
- R3: A frame is bit 0 = start (low), bits 1..8 = data with the LSB first, and bit 9 = parity. The parity is correct when data plus parity hold an even number of ones.
- R4: On correct parity, the byte is presented on `rx_data` and `rx_valid` is set. `line_pull_low` stays 0 through the error window.
- R5: On wrong parity, `per_flag` is set. `rx_valid` is not set by that frame and `rx_data` keeps its previous value.
- R6: After a parity error, `line_pull_low` rises half a bit time after the end of the parity bit and stays high for exactly `ERR_BITS` × `BIT_CYCLES` cycles. It then returns to 0.
- R7: `rx_valid` stays 1 until a cycle with `rx_ready` = 1 clears it. A good frame that arrives while `rx_valid` = 1 overwrites `rx_data`.
- R8: `per_flag` is sticky. Only a `per_clr` pulse clears it, and a good frame leaves it unchanged.
- R9: `rxi_irq` = `rx_valid` AND `rie`, and `eri_irq` = `per_flag` AND `rie`.
- R10: No new frame starts before the error window has ended, so the receiver's own error pulse is never taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; one bit is BIT_CYCLES cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level of the shared I/O line |
| line_pull_low | output | 1 | 1 = drive the line low; 0 = release it (high impedance) |
| rie | input | 1 | Receive-interrupt enable |
| rx_data | output | 8 | Last byte received with correct parity |
| rx_valid | output | 1 | A received byte is waiting to be read |
| rx_ready | input | 1 | Read strobe; completes the handshake and clears rx_valid |
| per_flag | output | 1 | Sticky parity-error flag |
| per_clr | input | 1 | Pulse that clears per_flag |
| rxi_irq | output | 1 | Receive interrupt request |
| eri_irq | output | 1 | Error interrupt request |

## Verification
One frame holds each bit at its true value only in a narrow window around cycle 186 and drives the opposite value for the rest of the bit. A receiver with a wrong sample point would therefore capture wrong data. The bench also times the error pulse: its first cycle and its length. A timer that is off by a bit or by half a bit would give the wrong values. After the pulse ends, the bench keeps watching the line to catch a receiver that re-triggers on its own pulse, which would show up as a second pulse. Further tests cover a short start glitch, which a weak start check would accept as a frame. They also check that a bad frame leaves `rx_data` and `rx_valid` alone, and that a later good frame does not clear the sticky error flag.

// File: rtl/scrx_pkg.sv
package scrx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SLOT = 2'd2
  } scrx_state_t;

endpackage

// File: rtl/scrx_sync_edge.sv
module scrx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain[0] <= line_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/scrx_bit_timer.sv
module scrx_bit_timer #(
  parameter int BIT_CYCLES = 372,
  parameter int SAMPLE_AT  = 186,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [IDX_W-1:0] bit_idx,
  output logic             mid_stb
);
  localparam int CNT_W = $clog2(BIT_CYCLES);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      bit_idx <= '0;
    end else if (!run) begin
      cnt     <= '0;
      bit_idx <= '0;
    end else if (cnt == CNT_W'(BIT_CYCLES - 1)) begin
      cnt     <= '0;
      bit_idx <= bit_idx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mid_stb = run && (cnt == CNT_W'(SAMPLE_AT));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(BIT_CYCLES)); // R2
endmodule

// File: rtl/scrx_frame_ctrl.sv
module scrx_frame_ctrl
  import scrx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int ERR_BITS  = 1,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall,
  input  logic                 line_s,
  input  logic                 mid_stb,
  input  logic [IDX_W-1:0]     bit_idx,
  output logic                 run,
  output logic                 pull_low,
  output logic                 good_stb,
  output logic                 bad_stb,
  output logic [DATA_BITS-1:0] frame_data
);
  localparam int PAR_IDX   = DATA_BITS + 1;
  localparam int ERR_FIRST = DATA_BITS + 2;
  localparam int ERR_LAST  = ERR_FIRST + ERR_BITS;

  scrx_state_t          state;
  logic [DATA_BITS-1:0] shreg;
  logic                 err_pend;
  logic                 par_ok;
  logic                 at_par;

  assign at_par   = (state == ST_DATA) && mid_stb && (bit_idx == IDX_W'(PAR_IDX));
  assign par_ok   = ~((^shreg) ^ line_s);
  assign good_stb = at_par && par_ok;
  assign bad_stb  = at_par && !par_ok;
  assign run      = (state != ST_IDLE);
  assign frame_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      err_pend <= 1'b0;
      pull_low <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          pull_low <= 1'b0;
          if (fall) state <= ST_DATA;
        end
        ST_DATA: begin
          if (mid_stb) begin
            if (bit_idx == '0) begin
              if (line_s) state <= ST_IDLE;
            end else if (bit_idx <= IDX_W'(DATA_BITS)) begin
              shreg <= {line_s, shreg[DATA_BITS-1:1]};
            end else begin
              err_pend <= !par_ok;
              state    <= ST_SLOT;
            end
          end
        end
        ST_SLOT: begin
          if (mid_stb && bit_idx == IDX_W'(ERR_FIRST) && err_pend) pull_low <= 1'b1;
          if (mid_stb && bit_idx == IDX_W'(ERR_LAST)) begin
            pull_low <= 1'b0;
            err_pend <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> (state == ST_SLOT)); // R6
  AST_GOOD_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOT && !err_pend) |-> !pull_low); // R4
  AST_NO_RESTART_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOT) |=> (state != ST_DATA)); // R10
endmodule

// File: rtl/scrx_status.sv
module scrx_status #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 good_stb,
  input  logic                 bad_stb,
  input  logic [DATA_BITS-1:0] data_in,
  input  logic                 rx_ready,
  input  logic                 per_clr,
  input  logic                 rie,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 per_flag,
  output logic                 rxi_irq,
  output logic                 eri_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      per_flag <= 1'b0;
    end else begin
      if (good_stb) begin
        rx_data  <= data_in;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (bad_stb)      per_flag <= 1'b1;
      else if (per_clr) per_flag <= 1'b0;
    end
  end

  assign rxi_irq = rie & rx_valid;
  assign eri_irq = rie & per_flag;

  AST_BAD_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stb |=> $stable(rx_data)); // R5
  AST_BAD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_stb && !rx_valid) |=> !rx_valid); // R5
  AST_HANDSHAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !good_stb) |=> !rx_valid); // R7
  AST_PER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (per_flag && !per_clr) |=> per_flag); // R8
endmodule

// File: rtl/scrx_rx.sv
module scrx_rx #(
  parameter int BIT_CYCLES  = 372,
  parameter int SAMPLE_AT   = 186,
  parameter int DATA_BITS   = 8,
  parameter int ERR_BITS    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  output logic                 line_pull_low,
  input  logic                 rie,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 per_flag,
  input  logic                 per_clr,
  output logic                 rxi_irq,
  output logic                 eri_irq
);
  localparam int IDX_W = $clog2(DATA_BITS + ERR_BITS + 4);

  logic                 line_s, fall, run, mid_stb, good_stb, bad_stb;
  logic [IDX_W-1:0]     bit_idx;
  logic [DATA_BITS-1:0] frame_data;

  scrx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_async(line_in), .line_s(line_s), .fall(fall)
  );

  scrx_bit_timer #(.BIT_CYCLES(BIT_CYCLES), .SAMPLE_AT(SAMPLE_AT), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_idx(bit_idx), .mid_stb(mid_stb)
  );

  scrx_frame_ctrl #(.DATA_BITS(DATA_BITS), .ERR_BITS(ERR_BITS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall(fall), .line_s(line_s), .mid_stb(mid_stb),
    .bit_idx(bit_idx), .run(run), .pull_low(line_pull_low), .good_stb(good_stb),
    .bad_stb(bad_stb), .frame_data(frame_data)
  );

  scrx_status #(.DATA_BITS(DATA_BITS)) u_status (
    .clk(clk), .rst_n(rst_n), .good_stb(good_stb), .bad_stb(bad_stb),
    .data_in(frame_data), .rx_ready(rx_ready), .per_clr(per_clr), .rie(rie),
    .rx_data(rx_data), .rx_valid(rx_valid), .per_flag(per_flag),
    .rxi_irq(rxi_irq), .eri_irq(eri_irq)
  );

  AST_PULL_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull_low) |-> per_flag); // R6
endmodule

// File: tb/scrx_rx_test.sv
`timescale 1ns/1ps
module scrx_rx_test;
  localparam int B = 372;
  localparam int S = 186;
  localparam int E = 1;
  localparam int PULSE_AT = 10*B + S + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_line = 1'b1;
  logic rie = 1'b0, rx_ready = 1'b0, per_clr = 1'b0;
  logic line_in, line_pull_low, rx_valid, per_flag, rxi_irq, eri_irq;
  logic [7:0] rx_data;
  int total = 0, bad = 0;
  logic [7:0] last_good = 8'h00;

  always #2.5 clk = ~clk;
  assign line_in = tb_line & ~line_pull_low;

  scrx_rx uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_pull_low(line_pull_low),
    .rie(rie), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .per_flag(per_flag), .per_clr(per_clr), .rxi_irq(rxi_irq), .eri_irq(eri_irq)
  );

  // entries: {rie, bad parity, data}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b0, 8'hA5}, {1'b1, 1'b1, 8'h3C}, {1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'hFF}, {1'b0, 1'b1, 8'h81}, {1'b1, 1'b0, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic badpar, input logic narrow,
                            output int first_low, output int low_cnt);
    logic [9:0] bits;
    bits = {(^d) ^ badpar, d, 1'b0};
    first_low = -1;
    low_cnt = 0;
    for (int c = 0; c < 13*B; c++) begin
      @(negedge clk);
      if (c > 0 && line_pull_low) begin
        if (first_low < 0) first_low = c;
        low_cnt++;
      end
      if (c < 10*B) begin
        int k, off;
        logic v;
        k = c / B;
        off = c % B;
        v = bits[k];
        if (narrow && k > 0 && (off < S - 30 || off > S + 30)) v = ~v;
        tb_line = v;
      end else begin
        tb_line = 1'b1;
      end
    end
  endtask

  task automatic consume();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear_per();
    @(negedge clk); per_clr = 1'b1;
    @(negedge clk); per_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fl, lc;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 valid", rx_valid, 0);
    chk("R1 per", per_flag, 0);
    chk("R1 pull", line_pull_low, 0);
    chk("R1 irqs", {rxi_irq, eri_irq}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // vector table: R3 R4 R5 R6 R9
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      logic bp;
      d = VEC[i][7:0];
      bp = VEC[i][8];
      rie = VEC[i][9];
      send_frame(d, bp, 1'b0, fl, lc);
      if (bp) begin
        chk("R5 valid stays low", rx_valid, 0);
        chk("R5 per set", per_flag, 1);
        chk("R5 data kept", rx_data, last_good);
        chk_range("R6 pulse start", fl, PULSE_AT - 2, PULSE_AT + 2);
        chk("R6 pulse length", lc, E*B);
        chk("R9 eri", eri_irq, rie);
        chk("R9 rxi", rxi_irq, 0);
      end else begin
        last_good = d;
        chk("R4 valid", rx_valid, 1);
        chk("R3 R4 data", rx_data, d);
        chk("R4 no pulse", lc, 0);
        chk("R4 per clear", per_flag, 0);
        chk("R9 rxi", rxi_irq, rie);
        chk("R9 eri", eri_irq, 0);
      end
      consume();
      clear_per();
      chk("R7 cleared by read", rx_valid, 0);
    end
    rie = 1'b1;

    // R7 hold and overwrite
    send_frame(8'h11, 1'b0, 1'b0, fl, lc);
    repeat (100) @(negedge clk);
    chk("R7 valid held", rx_valid, 1);
    send_frame(8'h22, 1'b0, 1'b0, fl, lc);
    chk("R7 overwrite data", rx_data, 8'h22);
    chk("R7 overwrite valid", rx_valid, 1);
    consume();
    chk("R7 handshake clears", rx_valid, 0);
    last_good = 8'h22;

    // R8 sticky error flag
    send_frame(8'h6E, 1'b1, 1'b0, fl, lc);
    chk("R8 per set", per_flag, 1);
    send_frame(8'h33, 1'b0, 1'b0, fl, lc);
    chk("R8 per survives good frame", per_flag, 1);
    chk("R8 good data", rx_data, 8'h33);
    clear_per();
    chk("R8 per cleared", per_flag, 0);
    consume();

    // R2 false start glitch
    @(negedge clk); tb_line = 1'b0;
    repeat (60) @(negedge clk);
    tb_line = 1'b1;
    lc = 0;
    for (int c = 0; c < 13*B; c++) begin
      @(negedge clk);
      if (line_pull_low) lc++;
    end
    chk("R2 glitch no valid", rx_valid, 0);
    chk("R2 glitch no per", per_flag, 0);
    chk("R2 glitch no drive", lc, 0);

    // R2 sample point: bits true only near cycle 186
    send_frame(8'hC6, 1'b0, 1'b1, fl, lc);
    chk("R2 narrow data", rx_data, 8'hC6);
    chk("R2 narrow valid", rx_valid, 1);
    consume();

    // R10 own pulse not a start bit
    send_frame(8'h47, 1'b1, 1'b0, fl, lc);
    chk("R10 first pulse", lc, E*B);
    lc = 0;
    for (int c = 0; c < 12*B; c++) begin
      @(negedge clk);
      if (line_pull_low) lc++;
    end
    chk("R10 no second pulse", lc, 0);
    chk("R10 no valid", rx_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule